// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a register port and the bus sequencer of a two-wire serial master. It keeps one byte queue for outgoing data and one for incoming data. Software writes outgoing bytes and reads incoming bytes through the register port. The sequencer takes bytes from the outgoing queue and pushes received bytes into the incoming queue. Each queue has a programmable 4-bit threshold and a flush control that clears itself when the flush is finished.

Every queue level condition and every event the sequencer reports lands in a 32-bit raw status word at a fixed bit position. Software enables bits in a mask word and sees the masked status. It clears sticky event bits by writing ones to a clear address. A single interrupt line is raised, one cycle later, whenever any masked status bit is set. A build parameter selects whether the block has a separate "finished without stop" bit. The flush is handled by a small state machine per queue with three states. `FL_IDLE` moves to `FL_HOLD` when software writes the flush control. `FL_HOLD` moves to `FL_WIPE` after `FLUSH_LAT` cycles. `FL_WIPE` empties the queue and moves back to `FL_IDLE`.

Register words are selected by `reg_addr`. 0 is control (bit 7 flushes TX, bit 8 flushes RX, and the bits read back as busy). 1 is TX data. 2 is RX data. 3 is the TX threshold. 4 is the RX threshold. 5 is the mask. 6 is raw status. 7 is masked status. 8 is clear. 9 is levels (TX count in bits 7:0, RX count in bits 15:8). Read data is registered and is valid the cycle after `reg_rd`.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset both queues are empty, the mask is 0, the irq line is low, the TX threshold reads 1, the RX threshold reads 7 (the default of 8 capped for DEPTH=16), and raw status reads 0x13.
- R2: Bytes written to TX data leave on `bus_tx_byte` in write order. A `bus_tx_pop` removes the head byte, and a pop on an empty queue is ignored.
- R3: Bytes pushed with `bus_rx_push` are read from RX data in arrival order, and each read removes one byte. A read of an empty RX queue returns 0. A push into a full RX queue is dropped.
- R4: The level bits in raw status follow the counts at all times. Bit 0 means TX is empty. Bit 1 means the TX count is at or below the TX threshold. Bit 2 means TX is full. Bit 4 means RX is empty. Bit 5 means the RX count is at or above the RX threshold. Bit 6 means RX is full.
- R5: A threshold write keeps bits 3:0 of the data, capped at DEPTH/2-1 (7 by default).
- R6: A TX data write while TX is full sets sticky bit 3 and the byte is discarded.
- R7: Sequencer events set sticky bits. Done with stop sets bit 19. Done without stop sets bit 28. Slave done sets bit 20. Arbitration lost sets bit 24. Bus error sets bit 25.
- R8: With `HAS_NOSTOP_DONE`=0, every done event sets bit 19, and bit 28 always reads 0.
- R9: A clear write resets only the sticky bits written as 1 within 0x131F007F. Level bits whose condition still holds keep reading 1.
- R10: The mask keeps bits 28:0 of the written data, so bits 31:29 read 0. Masked status reads raw AND mask.
- R11: `irq_o` equals the OR of the masked status of the previous cycle.
- R12: Writing 1 to a flush bit makes that bit read 1 while the flush runs. During the flush, accesses to that queue are ignored. The bit then clears by itself and the queue is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| bus_tx_pop | input | 1 | Sequencer takes the TX head byte |
| bus_tx_byte | output | 8 | TX head byte (0 when empty) |
| bus_rx_push | input | 1 | Sequencer delivers a received byte |
| bus_rx_byte | input | 8 | Received byte |
| ev_done | input | 1 | Transaction finished pulse |
| ev_stop | input | 1 | Qualifies `ev_done`: 1 = ended with stop |
| ev_slave_done | input | 1 | Slave transaction finished pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
A long seeded random mix of queue writes, pops, pushes, reads, events, clears, mask and threshold writes is checked against a behavioural queue model after every step. This tells ordering faults apart from level-flag and threshold-comparison faults. Directed cases drive the full queue, the overrun write, threshold values above the cap, clears of level bits and reserved mask bits. These catch off-by-one and bit-position mistakes that random traffic seldom reaches. A second instance built without the no-stop bit runs on the same stimulus, which separates the two done-reporting variants. Flush sequences and an irq timing probe check the self-clearing control and the one-cycle interrupt delay.

// File: rtl/fic_pkg.sv
package fic_pkg;
    localparam int B_TX_EMPTY    = 0;
    localparam int B_TX_LOW      = 1;
    localparam int B_TX_FULL     = 2;
    localparam int B_TX_OVR      = 3;
    localparam int B_RX_EMPTY    = 4;
    localparam int B_RX_HIGH     = 5;
    localparam int B_RX_FULL     = 6;
    localparam int B_DONE_STOP   = 19;
    localparam int B_SLV_DONE    = 20;
    localparam int B_ARB_LOST    = 24;
    localparam int B_BUS_ERR     = 25;
    localparam int B_DONE_NOSTOP = 28;

    localparam logic [31:0] CLEARABLE  = 32'h131F_007F;
    localparam logic [31:0] MASK_BITS  = 32'h1FFF_FFFF;
    localparam logic [31:0] LEVEL_BITS = 32'h0000_0077;

    localparam int CTRL_TX_FLUSH = 7;
    localparam int CTRL_RX_FLUSH = 8;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_TXD   = 4'd1,
        A_RXD   = 4'd2,
        A_TXTH  = 4'd3,
        A_RXTH  = 4'd4,
        A_MASK  = 4'd5,
        A_RAW   = 4'd6,
        A_MSTAT = 4'd7,
        A_CLEAR = 4'd8,
        A_LEVEL = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_HOLD = 2'd1,
        FL_WIPE = 2'd2
    } flush_state_e;
endpackage

// File: rtl/fic_fifo.sv
module fic_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          wipe,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !wipe) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R6: a full queue never grows past its depth
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !wipe) |=> full);

    // R2: popping an empty queue leaves it empty
    a_r2_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/fic_flush.sv
module fic_flush
    import fic_pkg::*;
#(
    parameter int FLUSH_LAT = 4,
    localparam int NW       = $clog2(FLUSH_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic wipe
);
    flush_state_e state, state_nx;
    logic [NW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FL_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != FL_HOLD) begin
            hold_cnt <= '0;
        end else begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FL_IDLE: if (start) state_nx = FL_HOLD;
            FL_HOLD: if (hold_cnt == NW'(FLUSH_LAT - 1)) state_nx = FL_WIPE;
            FL_WIPE: state_nx = FL_IDLE;
            default: state_nx = FL_IDLE;
        endcase
    end

    always_comb begin
        busy = (state != FL_IDLE);
        wipe = (state == FL_WIPE);
    end

    // R12: a flush always passes through the wipe state before going idle
    a_r12_wipe_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_HOLD && state_nx == FL_IDLE) |-> 1'b0);
endmodule

// File: rtl/fic_irq.sv
module fic_irq
    import fic_pkg::*;
#(
    parameter bit HAS_NOSTOP_DONE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] level_vec,
    input  logic        ev_ovr,
    input  logic        ev_done,
    input  logic        ev_stop,
    input  logic        ev_slave,
    input  logic        ev_arb,
    input  logic        ev_berr,
    input  logic        mask_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    output logic [31:0] raw,
    output logic [31:0] mask,
    output logic [31:0] mstat,
    output logic        irq
);
    logic [31:0] sticky;
    logic [31:0] set_vec;
    logic [31:0] clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[B_TX_OVR]   = ev_ovr;
        set_vec[B_SLV_DONE] = ev_slave;
        set_vec[B_ARB_LOST] = ev_arb;
        set_vec[B_BUS_ERR]  = ev_berr;
        if (ev_done) begin
            if (HAS_NOSTOP_DONE && !ev_stop) begin
                set_vec[B_DONE_NOSTOP] = 1'b1;
            end else begin
                set_vec[B_DONE_STOP] = 1'b1;
            end
        end
        clr_vec = clr_we ? (wdata & CLEARABLE) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= '0;
            mask   <= '0;
            irq    <= 1'b0;
        end else begin
            sticky <= (sticky & ~clr_vec) | set_vec;
            if (mask_we) begin
                mask <= wdata & MASK_BITS;
            end
            irq <= |mstat;
        end
    end

    assign raw   = sticky | (level_vec & LEVEL_BITS);
    assign mstat = raw & mask;

    generate
        if (HAS_NOSTOP_DONE) begin : g_nostop
            // R7: done without stop lands on its own bit
            a_r7_nostop_bit: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_done && !ev_stop) |=> raw[B_DONE_NOSTOP]);
        end else begin : g_stop_only
            // R8: without the variant every done reports on the stop bit
            a_r8_folded_done: assert property (@(posedge clk) disable iff (!rst_n)
                ev_done |=> (raw[B_DONE_STOP] && !raw[B_DONE_NOSTOP]));
        end
    endgenerate

    // R7: arbitration loss is latched
    a_r7_arb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb |=> raw[B_ARB_LOST]);

    // R9: clearing a sticky bit with no new event leaves it low
    a_r9_clear_arb: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wdata[B_ARB_LOST] && !ev_arb) |=> !raw[B_ARB_LOST]);

    // R11: the line only rises after a masked bit was set
    a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(raw & mask)));
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fic_pkg::*;
#(
    parameter int DEPTH           = 16,
    parameter int FLUSH_LAT       = 4,
    parameter bit HAS_NOSTOP_DONE = 1'b1,
    localparam int CW             = $clog2(DEPTH) + 1,
    localparam int THR_MAX        = (DEPTH / 2 - 1 > 15) ? 15 : DEPTH / 2 - 1,
    localparam int TX_THR_RST     = (1 > THR_MAX) ? THR_MAX : 1,
    localparam int RX_THR_RST     = (8 > THR_MAX) ? THR_MAX : 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        bus_tx_pop,
    output logic [7:0]  bus_tx_byte,
    input  logic        bus_rx_push,
    input  logic [7:0]  bus_rx_byte,
    input  logic        ev_done,
    input  logic        ev_stop,
    input  logic        ev_slave_done,
    input  logic        ev_arb_lost,
    input  logic        ev_bus_err,
    output logic        irq_o
);
    reg_addr_e   addr;
    logic        sel_ctrl, sel_txd, sel_rxd, sel_txth, sel_rxth, sel_mask, sel_clr;
    logic [3:0]  tx_thr, rx_thr;
    logic        tx_busy, rx_busy, tx_wipe, rx_wipe;
    logic [7:0]  tx_dout, rx_dout;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic        tx_wr_ok, tx_ovr, rx_rd_ok;
    logic [31:0] level_vec, raw, mask, mstat, rd_mux;

    assign addr     = reg_addr_e'(reg_addr);
    assign sel_ctrl = reg_wr && addr == A_CTRL;
    assign sel_txd  = reg_wr && addr == A_TXD;
    assign sel_rxd  = reg_rd && addr == A_RXD;
    assign sel_txth = reg_wr && addr == A_TXTH;
    assign sel_rxth = reg_wr && addr == A_RXTH;
    assign sel_mask = reg_wr && addr == A_MASK;
    assign sel_clr  = reg_wr && addr == A_CLEAR;

    assign tx_wr_ok = sel_txd && !tx_busy;
    assign tx_ovr   = tx_wr_ok && tx_full;
    assign rx_rd_ok = sel_rxd && !rx_busy;

    function automatic logic [3:0] cap_thr(input logic [3:0] v);
        return (int'(v) > THR_MAX) ? 4'(THR_MAX) : v;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= 4'(TX_THR_RST);
            rx_thr <= 4'(RX_THR_RST);
        end else begin
            if (sel_txth) tx_thr <= cap_thr(reg_wdata[3:0]);
            if (sel_rxth) rx_thr <= cap_thr(reg_wdata[3:0]);
        end
    end

    fic_flush #(.FLUSH_LAT(FLUSH_LAT)) u_tx_flush (
        .clk(clk), .rst_n(rst_n),
        .start(sel_ctrl && reg_wdata[CTRL_TX_FLUSH]),
        .busy(tx_busy), .wipe(tx_wipe)
    );

    fic_flush #(.FLUSH_LAT(FLUSH_LAT)) u_rx_flush (
        .clk(clk), .rst_n(rst_n),
        .start(sel_ctrl && reg_wdata[CTRL_RX_FLUSH]),
        .busy(rx_busy), .wipe(rx_wipe)
    );

    fic_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_q (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr_ok), .pop(bus_tx_pop && !tx_busy), .wipe(tx_wipe),
        .din(reg_wdata[7:0]), .dout(tx_dout), .count(tx_cnt),
        .empty(tx_empty), .full(tx_full)
    );

    fic_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_q (
        .clk(clk), .rst_n(rst_n),
        .push(bus_rx_push && !rx_busy), .pop(rx_rd_ok), .wipe(rx_wipe),
        .din(bus_rx_byte), .dout(rx_dout), .count(rx_cnt),
        .empty(rx_empty), .full(rx_full)
    );

    assign bus_tx_byte = tx_empty ? 8'h00 : tx_dout;

    always_comb begin
        level_vec = '0;
        level_vec[B_TX_EMPTY] = tx_empty;
        level_vec[B_TX_LOW]   = 32'(tx_cnt) <= 32'(tx_thr);
        level_vec[B_TX_FULL]  = tx_full;
        level_vec[B_RX_EMPTY] = rx_empty;
        level_vec[B_RX_HIGH]  = 32'(rx_cnt) >= 32'(rx_thr);
        level_vec[B_RX_FULL]  = rx_full;
    end

    fic_irq #(.HAS_NOSTOP_DONE(HAS_NOSTOP_DONE)) u_irq (
        .clk(clk), .rst_n(rst_n), .level_vec(level_vec),
        .ev_ovr(tx_ovr), .ev_done(ev_done), .ev_stop(ev_stop),
        .ev_slave(ev_slave_done), .ev_arb(ev_arb_lost), .ev_berr(ev_bus_err),
        .mask_we(sel_mask), .clr_we(sel_clr), .wdata(reg_wdata),
        .raw(raw), .mask(mask), .mstat(mstat), .irq(irq_o)
    );

    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CTRL: begin
                rd_mux[CTRL_TX_FLUSH] = tx_busy;
                rd_mux[CTRL_RX_FLUSH] = rx_busy;
            end
            A_RXD:   rd_mux = (rx_busy || rx_empty) ? '0 : 32'(rx_dout);
            A_TXTH:  rd_mux = 32'(tx_thr);
            A_RXTH:  rd_mux = 32'(rx_thr);
            A_MASK:  rd_mux = mask;
            A_RAW:   rd_mux = raw;
            A_MSTAT: rd_mux = mstat;
            A_LEVEL: rd_mux = (32'(rx_cnt) << 8) | 32'(tx_cnt);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    // R12: a finished flush leaves its queue empty
    a_r12_tx_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> tx_empty);
    a_r12_rx_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_busy) |-> rx_empty);

    // R6: an overrun write leaves the TX count unchanged
    a_r6_ovr_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovr && !bus_tx_pop) |=> $stable(tx_cnt));

    // R5: thresholds never exceed the cap
    a_r5_thr_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tx_thr) <= THR_MAX) && (32'(rx_thr) <= THR_MAX));
endmodule

// File: tb/tb_fifo_irq_ctrl.sv
module tb_fifo_irq_ctrl;
    localparam int DEPTH = 16;
    localparam int THR_MAX = 7;
    localparam logic [31:0] CLR_M = 32'h131F_007F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0;
    logic [3:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] rdata, rdata_nv;
    logic bus_tx_pop = 0, bus_rx_push = 0;
    logic [7:0] bus_rx_byte = 0, tx_byte, tx_byte_nv;
    logic ev_done = 0, ev_stop = 0, ev_slave_done = 0, ev_arb_lost = 0, ev_bus_err = 0;
    logic irq, irq_nv;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0] m_tx[$];
    logic [7:0] m_rx[$];
    logic [31:0] m_st = 0, m_st_nv = 0, m_mask = 0;
    int m_txth = 1, m_rxth = 7;

    always #10 clk = ~clk;

    fifo_irq_ctrl #(.DEPTH(DEPTH), .FLUSH_LAT(4), .HAS_NOSTOP_DONE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .bus_tx_pop(bus_tx_pop),
        .bus_tx_byte(tx_byte), .bus_rx_push(bus_rx_push), .bus_rx_byte(bus_rx_byte),
        .ev_done(ev_done), .ev_stop(ev_stop), .ev_slave_done(ev_slave_done),
        .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err), .irq_o(irq));

    fifo_irq_ctrl #(.DEPTH(DEPTH), .FLUSH_LAT(4), .HAS_NOSTOP_DONE(1'b0)) dut_nv (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_nv), .bus_tx_pop(bus_tx_pop),
        .bus_tx_byte(tx_byte_nv), .bus_rx_push(bus_rx_push), .bus_rx_byte(bus_rx_byte),
        .ev_done(ev_done), .ev_stop(ev_stop), .ev_slave_done(ev_slave_done),
        .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err), .irq_o(irq_nv));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] levels();
        logic [31:0] v = 0;
        v[0] = (m_tx.size() == 0);
        v[1] = (m_tx.size() <= m_txth);
        v[2] = (m_tx.size() == DEPTH);
        v[4] = (m_rx.size() == 0);
        v[5] = (m_rx.size() >= m_rxth);
        v[6] = (m_rx.size() == DEPTH);
        return v;
    endfunction

    function automatic logic [31:0] exp_raw();
        return m_st | levels();
    endfunction

    function automatic logic [31:0] exp_raw_nv();
        return m_st_nv | levels();
    endfunction

    function automatic int cap(input logic [31:0] w);
        return (int'(w[3:0]) > THR_MAX) ? THR_MAX : int'(w[3:0]);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic tx_write(input logic [7:0] b);
        wr(4'd1, {24'h0, b});
        if (m_tx.size() == DEPTH) begin
            m_st[3] = 1; m_st_nv[3] = 1;
        end else m_tx.push_back(b);
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        bus_rx_push = 1; bus_rx_byte = b;
        @(negedge clk);
        bus_rx_push = 0;
        if (m_rx.size() < DEPTH) m_rx.push_back(b);
    endtask

    task automatic rx_read();
        logic [7:0] e;
        e = (m_rx.size() == 0) ? 8'h00 : m_rx[0];
        rd(4'd2);
        chk(rdata == {24'h0, e}, "R3 rx read order", rdata, {24'h0, e});
        if (m_rx.size() != 0) void'(m_rx.pop_front());
    endtask

    task automatic tx_pop();
        logic [7:0] e;
        @(negedge clk);
        e = (m_tx.size() == 0) ? 8'h00 : m_tx[0];
        chk(tx_byte == e, "R2 tx head byte", {24'h0, tx_byte}, {24'h0, e});
        bus_tx_pop = 1;
        @(negedge clk);
        bus_tx_pop = 0;
        if (m_tx.size() != 0) void'(m_tx.pop_front());
    endtask

    task automatic event_pulse(input int kind, input bit stop);
        @(negedge clk);
        case (kind)
            0: begin ev_done = 1; ev_stop = stop; end
            1: ev_slave_done = 1;
            2: ev_arb_lost = 1;
            default: ev_bus_err = 1;
        endcase
        @(negedge clk);
        ev_done = 0; ev_stop = 0; ev_slave_done = 0; ev_arb_lost = 0; ev_bus_err = 0;
        case (kind)
            0: begin
                if (stop) m_st[19] = 1; else m_st[28] = 1;
                m_st_nv[19] = 1;
            end
            1: begin m_st[20] = 1; m_st_nv[20] = 1; end
            2: begin m_st[24] = 1; m_st_nv[24] = 1; end
            default: begin m_st[25] = 1; m_st_nv[25] = 1; end
        endcase
    endtask

    task automatic clear(input logic [31:0] w);
        wr(4'd8, w);
        m_st = m_st & ~(w & CLR_M);
        m_st_nv = m_st_nv & ~(w & CLR_M);
    endtask

    task automatic check_state(input string tag);
        logic [31:0] e, env;
        e = exp_raw(); env = exp_raw_nv();
        rd(4'd6);
        chk(rdata == e, {tag, " R4 raw"}, rdata, e);
        chk(rdata_nv == env, {tag, " R8 raw variant"}, rdata_nv, env);
        chk(irq == |(e & m_mask), {tag, " R11 irq"}, {31'h0, irq}, {31'h0, |(e & m_mask)});
        rd(4'd9);
        chk(rdata == ((32'(m_rx.size()) << 8) | 32'(m_tx.size())), {tag, " R2 levels"},
            rdata, (32'(m_rx.size()) << 8) | 32'(m_tx.size()));
    endtask

    task automatic run_flush(input int which);
        int polls;
        logic [31:0] bit_v;
        bit_v = (which == 0) ? 32'h80 : 32'h100;
        wr(4'd0, bit_v);
        rd(4'd0);
        chk((rdata & bit_v) == bit_v, "R12 flush bit set", rdata, bit_v);
        if (which == 0) wr(4'd1, 32'h5A); else rx_push(8'h5A);
        polls = 0;
        do begin
            rd(4'd0);
            polls++;
        end while ((rdata & bit_v) != 0 && polls < 20);
        chk((rdata & bit_v) == 0, "R12 flush self clears", rdata, 0);
        if (which == 0) m_tx.delete(); else m_rx.delete();
        check_state("R12 after flush");
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'd6);  chk(rdata == 32'h13, "R1 raw reset", rdata, 32'h13);
        rd(4'd5);  chk(rdata == 0, "R1 mask reset", rdata, 0);
        rd(4'd3);  chk(rdata == 1, "R1 tx thr reset", rdata, 1);
        rd(4'd4);  chk(rdata == 7, "R1 rx thr reset", rdata, 7);
        rd(4'd9);  chk(rdata == 0, "R1 levels reset", rdata, 0);
        chk(irq == 0, "R1 irq reset", {31'h0, irq}, 0);

        // R5 threshold cap
        wr(4'd3, 32'hFF); m_txth = cap(32'hFF);
        rd(4'd3); chk(rdata == 7, "R5 tx thr cap", rdata, 7);
        wr(4'd3, 32'h2); m_txth = 2;
        rd(4'd3); chk(rdata == 2, "R5 tx thr in range", rdata, 2);

        // R10 mask reserved bits
        wr(4'd5, 32'hFFFF_FFFF); m_mask = 32'h1FFF_FFFF;
        rd(4'd5); chk(rdata == 32'h1FFF_FFFF, "R10 mask top bits", rdata, 32'h1FFF_FFFF);
        rd(4'd7); chk(rdata == exp_raw(), "R10 masked status", rdata, exp_raw());

        // R2/R6 fill TX to full then overrun
        for (int i = 0; i < DEPTH; i++) tx_write(8'(i + 8'h30));
        check_state("R4 tx full");
        tx_write(8'hEE);
        check_state("R6 overrun");
        rd(4'd6); chk(rdata[3] == 1'b1, "R6 overrun bit", rdata, exp_raw());
        for (int i = 0; i < 3; i++) tx_pop();

        // R9 clear everything: level bits persist, sticky gone
        clear(32'hFFFF_FFFF);
        check_state("R9 clear all");
        rd(4'd6); chk(rdata[3] == 1'b0, "R9 overrun cleared", rdata, exp_raw());

        // R3 rx order and empty read
        rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
        rx_read(); rx_read(); rx_read(); rx_read();

        // R4 rx high threshold boundary
        wr(4'd4, 32'h3); m_rxth = 3;
        rx_push(8'hA1); rx_push(8'hA2);
        check_state("R4 rx below thr");
        rx_push(8'hA3);
        check_state("R4 rx at thr");

        // R7/R8 done without stop on both variants
        event_pulse(0, 1'b0);
        rd(4'd6); chk(rdata[28] == 1'b1, "R7 nostop bit", rdata, exp_raw());
        chk(rdata_nv[19] == 1'b1 && rdata_nv[28] == 1'b0, "R8 folded done", rdata_nv, exp_raw_nv());
        clear(32'hFFFF_FFFF);

        // R11 irq one cycle after the raw bit
        wr(4'd5, 32'h0100_0000); m_mask = 32'h0100_0000;
        @(negedge clk); ev_arb_lost = 1;
        @(negedge clk); ev_arb_lost = 0;
        chk(irq == 1'b0, "R11 irq not yet", {31'h0, irq}, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R11 irq raised", {31'h0, irq}, 1);
        m_st[24] = 1; m_st_nv[24] = 1;
        clear(32'h0100_0000);
        @(negedge clk);
        chk(irq == 1'b0, "R11 irq dropped", {31'h0, irq}, 0);

        // R12 flushes
        run_flush(0);
        run_flush(1);

        // random mix
        for (int it = 0; it < 500; it++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0, 1: tx_write(8'($urandom));
                2: tx_pop();
                3, 4: rx_push(8'($urandom));
                5: rx_read();
                6: event_pulse(int'($urandom % 4), 1'($urandom));
                7: clear($urandom & $urandom);
                8: begin
                    logic [31:0] w;
                    w = $urandom;
                    wr(4'd5, w); m_mask = w & 32'h1FFF_FFFF;
                end
                default: begin
                    logic [31:0] w;
                    w = $urandom;
                    if (w[31]) begin wr(4'd3, w); m_txth = cap(w); end
                    else begin wr(4'd4, w); m_rxth = cap(w); end
                end
            endcase
            check_state("random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule